// File: doc/BRIEF.md
# Undocumented Opcode Class Decoder

This block sits beside the instruction decoder of an 8-bit accumulator CPU core. It classifies each fetched opcode byte. Opcodes outside the published instruction set are sorted into seven classes: operand-free no-ops, no-ops that still fetch an operand, jam codes, fused read-modify-write operations, fused stores, fused loads and fused immediate operations. Every other code is reported as official, so the surrounding core can send it to its normal decoder. For each opcode the block also gives an addressing-mode selector, taken from the low five opcode bits, and a nominal cycle count.

Classification, mode and cycle count are combinational in the opcode. The only state is a halt flag. When a jam opcode is presented with its valid strobe, the flag is set. From then on the block requests a fetch stall on every cycle until a synchronous reset clears it. Address generation, bus traffic and the arithmetic itself belong to other blocks.

Top module: `undocOpDecoder`

## Requirements
- R1: Opcodes 0x1A, 0x3A, 0x5A, 0x7A, 0xDA and 0xFA give class 1 (implied no-op), mode 0 (implied) and a cycle count of 2.
- R2: Opcodes 0x04, 0x44, 0x64, 0x0C, 0x80, 0x82, 0x89, 0xC2, 0xE2, plus 0x14, 0x34, 0x54, 0x74, 0xD4, 0xF4, 0x1C, 0x3C, 0x5C, 0x7C, 0xDC and 0xFC give class 2 (operand-fetching no-op). Their cycle count equals the count of their addressing mode.
- R3: Opcodes 0x02, 0x12, 0x22, 0x32, 0x42, 0x52, 0x62, 0x72, 0x92, 0xB2, 0xD2 and 0xF2 give class 3 (jam) with a cycle count of 0.
- R4: A jam opcode presented while opValid is 1 sets halted at the next rising clock edge, and fetchStall is 1 whenever halted is 1. A jam opcode presented while opValid is 0 leaves halted at 0.
- R5: halted is 0 after reset. Once set, halted stays 1 whatever opcodes follow, and only a synchronous reset (rst high at a rising edge) clears it.
- R6: The mode depends only on opcode bits [4:0]. 0x00, 0x02, 0x09 and 0x0B give 1 (immediate). 0x01 and 0x03 give 7 (indexed indirect). 0x04 to 0x07 give 2 (zero page). 0x0C to 0x0F give 4 (absolute). 0x11 and 0x13 give 8 (indirect indexed). 0x14 to 0x17 give 3 (zero page indexed). 0x19 and 0x1B give 6 (absolute Y). 0x1C to 0x1F give 5 (absolute X). Every other value gives 0 (implied).
- R7: The cycle count for each mode is: implied 2, immediate 2, zero page 3, zero page indexed 4, absolute 4, absolute X 4, absolute Y 4, indexed indirect 6, indirect indexed 5.
- R8: Opcodes whose low nibble is 3, 7 or F and whose high nibble is outside 8 to B, together with 0x1B, 0x3B, 0x5B, 0x7B, 0xDB and 0xFB, give class 4 (fused read-modify-write). Their cycle count is the mode count plus 2.
- R9: Opcodes 0x83, 0x87, 0x8F, 0x97, 0x93, 0x9B, 0x9C, 0x9E and 0x9F give class 5 (fused store). The high-byte-masked stores 0x93, 0x9B, 0x9C, 0x9E and 0x9F take the mode count plus 2. The other stores take the mode count.
- R10: Opcodes 0xA3, 0xA7, 0xAF, 0xB3, 0xB7, 0xBF and 0xBB give class 6 (fused load) with the mode count.
- R11: Opcodes 0x0B, 0x2B, 0x4B, 0x6B, 0x8B, 0xAB and 0xCB give class 7 (fused immediate) with the mode count. 0xEB is an ordinary subtract and gives class 0.
- R12: Every opcode not named in R1 to R3 or R8 to R11 gives class 0 (official) with the mode count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | The opcode byte is a real fetch this cycle |
| opcode | input | 8 | Fetched opcode byte |
| opClass | output | 3 | Class code (0 official to 7 fused immediate) |
| addrMode | output | 4 | Addressing-mode selector |
| baseCycles | output | 4 | Nominal cycle count |
| halted | output | 1 | Sticky jam flag |
| fetchStall | output | 1 | Holds instruction fetch while halted |

## Verification
The hardest state to reach is a core that has halted and then keeps receiving valid opcodes. Only a jam code with the strobe raised gets there. The stimulus presents a jam code with the strobe low, then with the strobe high, and then drives a run of valid official and jam codes. It checks that nothing releases the stall before the reset. The classification is also swept over all 256 opcode values against a model built from opcode lists.

// File: rtl/uopPkg.sv
package uopPkg;
  localparam int OP_W  = 8;
  localparam int CYC_W = 4;
  localparam int MODE_W = 4;

  typedef enum logic [2:0] {
    CLS_OFFICIAL = 3'd0,
    CLS_NOP_IMPL = 3'd1,
    CLS_NOP_OPER = 3'd2,
    CLS_JAM      = 3'd3,
    CLS_RMW      = 3'd4,
    CLS_STORE    = 3'd5,
    CLS_LOAD     = 3'd6,
    CLS_IMM      = 3'd7
  } opClass_e;

  typedef enum logic [MODE_W-1:0] {
    AM_IMPL = 4'd0,
    AM_IMM  = 4'd1,
    AM_ZP   = 4'd2,
    AM_ZPX  = 4'd3,
    AM_ABS  = 4'd4,
    AM_ABSX = 4'd5,
    AM_ABSY = 4'd6,
    AM_INDX = 4'd7,
    AM_INDY = 4'd8
  } addrMode_e;

  typedef struct packed {
    logic latchHalt;
    logic clearHalt;
  } haltStrobe_t;
endpackage

// File: rtl/uopDatapath.sv
module uopDatapath
  import uopPkg::*;
#(
  parameter int RMW_EXTRA = 2,
  parameter int HB_EXTRA  = 2
) (
  input  logic                clk,
  input  haltStrobe_t         strb,
  input  logic [OP_W-1:0]     opcode,
  output opClass_e            curClass,
  output addrMode_e           curMode,
  output logic [CYC_W-1:0]    curCycles,
  output logic                haltQ
);
  localparam int N_HIT = 7;

  logic [3:0] lo, hi;
  logic       hiOdd, hiMid;
  logic       jamHit, nopiHit, nopoHit, rmwHit, storeHit, loadHit, immHit, hbStore;
  logic [N_HIT-1:0] hitVec;
  logic [CYC_W-1:0] modeCyc;

  assign lo    = opcode[3:0];
  assign hi    = opcode[7:4];
  assign hiOdd = hi[0];
  assign hiMid = (hi[3:2] == 2'b10);

  always_comb begin
    jamHit   = (lo == 4'h2) && (hiOdd || !hi[3]);
    nopiHit  = (lo == 4'hA) && hiOdd && !hiMid;
    nopoHit  = (((lo == 4'h4) || (lo == 4'hC)) && hiOdd && !hiMid) ||
               (opcode inside {8'h04, 8'h44, 8'h64, 8'h0C, 8'h80, 8'h82, 8'h89, 8'hC2, 8'hE2});
    rmwHit   = !hiMid && ((lo == 4'h3) || (lo == 4'h7) || (lo == 4'hF) ||
                          ((lo == 4'hB) && hiOdd));
    storeHit = ((hi == 4'h8) && (lo inside {4'h3, 4'h7, 4'hF})) ||
               ((hi == 4'h9) && (lo inside {4'h3, 4'h7, 4'hB, 4'hC, 4'hE, 4'hF}));
    hbStore  = (hi == 4'h9) && storeHit && (lo != 4'h7);
    loadHit  = ((hi == 4'hA) && (lo inside {4'h3, 4'h7, 4'hF})) ||
               ((hi == 4'hB) && (lo inside {4'h3, 4'h7, 4'hB, 4'hF}));
    immHit   = (lo == 4'hB) && !hiOdd && (opcode != 8'hEB);
  end

  assign hitVec = {immHit, loadHit, storeHit, rmwHit, jamHit, nopoHit, nopiHit};

  // mode selector from the low five bits
  always_comb begin
    unique casez (opcode[4:0])
      5'h00, 5'h02, 5'h09, 5'h0B: curMode = AM_IMM;
      5'h01, 5'h03:               curMode = AM_INDX;
      5'b001??:                   curMode = AM_ZP;
      5'b011??:                   curMode = AM_ABS;
      5'h11, 5'h13:               curMode = AM_INDY;
      5'b101??:                   curMode = AM_ZPX;
      5'h19, 5'h1B:               curMode = AM_ABSY;
      5'b111??:                   curMode = AM_ABSX;
      default:                    curMode = AM_IMPL;
    endcase
  end

  always_comb begin
    unique case (curMode)
      AM_ZP:                   modeCyc = CYC_W'(3);
      AM_ZPX, AM_ABS,
      AM_ABSX, AM_ABSY:        modeCyc = CYC_W'(4);
      AM_INDX:                 modeCyc = CYC_W'(6);
      AM_INDY:                 modeCyc = CYC_W'(5);
      default:                 modeCyc = CYC_W'(2);
    endcase
  end

  always_comb begin
    curClass  = CLS_OFFICIAL;
    curCycles = modeCyc;
    if (jamHit) begin
      curClass  = CLS_JAM;
      curCycles = '0;
    end else if (nopiHit) begin
      curClass  = CLS_NOP_IMPL;
      curCycles = CYC_W'(2);
    end else if (nopoHit) begin
      curClass  = CLS_NOP_OPER;
    end else if (rmwHit) begin
      curClass  = CLS_RMW;
      curCycles = modeCyc + CYC_W'(RMW_EXTRA);
    end else if (storeHit) begin
      curClass  = CLS_STORE;
      if (hbStore) curCycles = modeCyc + CYC_W'(HB_EXTRA);
    end else if (loadHit) begin
      curClass  = CLS_LOAD;
    end else if (immHit) begin
      curClass  = CLS_IMM;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.clearHalt)      haltQ <= 1'b0;
    else if (strb.latchHalt) haltQ <= 1'b1;
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (strb.clearHalt)
    haltQ |=> haltQ); // R5
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (strb.clearHalt)
    $onehot0(hitVec)); // R12
  AST_NOPI_TWO: assert property (@(posedge clk) disable iff (strb.clearHalt)
    (curClass == CLS_NOP_IMPL) |-> (curCycles == CYC_W'(2) && curMode == AM_IMPL)); // R1
  AST_RMW_LONGER: assert property (@(posedge clk) disable iff (strb.clearHalt)
    (curClass == CLS_RMW) |-> (curCycles > CYC_W'(4))); // R8
endmodule

// File: rtl/uopCtrl.sv
module uopCtrl
  import uopPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        opValid,
  input  opClass_e    curClass,
  input  logic        haltedQ,
  output haltStrobe_t strb
);
  logic jamSeen;

  assign jamSeen        = opValid && (curClass == CLS_JAM);
  assign strb.clearHalt = rst;
  assign strb.latchHalt = jamSeen && !haltedQ;

  AST_JAM_LATCHES: assert property (@(posedge clk) disable iff (rst)
    jamSeen |=> haltedQ); // R4
  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(haltedQ) |-> $past(jamSeen)); // R4
endmodule

// File: rtl/undocOpDecoder.sv
module undocOpDecoder
  import uopPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                opValid,
  input  logic [OP_W-1:0]     opcode,
  output logic [2:0]          opClass,
  output logic [MODE_W-1:0]   addrMode,
  output logic [CYC_W-1:0]    baseCycles,
  output logic                halted,
  output logic                fetchStall
);
  haltStrobe_t strb;
  opClass_e    curClass;
  addrMode_e   curMode;
  logic        haltQ;

  uopCtrl uCtrl (
    .clk(clk), .rst(rst), .opValid(opValid),
    .curClass(curClass), .haltedQ(haltQ), .strb(strb)
  );

  uopDatapath #(.RMW_EXTRA(2), .HB_EXTRA(2)) uDp (
    .clk(clk), .strb(strb), .opcode(opcode),
    .curClass(curClass), .curMode(curMode),
    .curCycles(baseCycles), .haltQ(haltQ)
  );

  assign opClass    = curClass;
  assign addrMode   = curMode;
  assign halted     = haltQ;
  assign fetchStall = haltQ;
endmodule

// File: tb/sim_undocOpDecoder.sv
module sim_undocOpDecoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       opValid = 1'b0;
  logic [7:0] opcode = 8'hEA;
  logic [2:0] opClass;
  logic [3:0] addrMode;
  logic [3:0] baseCycles;
  logic       halted, fetchStall;
  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  undocOpDecoder u0 (
    .clk(clk), .rst(rst), .opValid(opValid), .opcode(opcode),
    .opClass(opClass), .addrMode(addrMode), .baseCycles(baseCycles),
    .halted(halted), .fetchStall(fetchStall)
  );

  // {opcode, class, mode, cycles}
  localparam int NV = 29;
  localparam logic [19:0] VEC [NV] = '{
    20'h1A_1_0_2, 20'hFA_1_0_2, 20'h04_2_2_3, 20'h0C_2_4_4, 20'h14_2_3_4,
    20'h1C_2_5_4, 20'h80_2_1_2, 20'h02_3_1_0, 20'hF2_3_0_0, 20'h03_4_7_8,
    20'h07_4_2_5, 20'h1B_4_6_6, 20'h13_4_8_7, 20'h1F_4_5_6, 20'h83_5_7_6,
    20'h97_5_3_4, 20'h9C_5_5_6, 20'h93_5_8_7, 20'hA7_6_2_3, 20'hBB_6_6_4,
    20'h0B_7_1_2, 20'hAB_7_1_2, 20'hEB_0_1_2, 20'hA9_0_1_2, 20'h00_0_1_2,
    20'hEA_0_0_2, 20'h6D_0_4_4, 20'hB1_0_8_5, 20'h9E_5_5_6
  };

  function automatic int expMode(input logic [7:0] op);
    case (op[4:0])
      5'h00, 5'h02, 5'h09, 5'h0B: return 1;
      5'h01, 5'h03: return 7;
      5'h04, 5'h05, 5'h06, 5'h07: return 2;
      5'h0C, 5'h0D, 5'h0E, 5'h0F: return 4;
      5'h11, 5'h13: return 8;
      5'h14, 5'h15, 5'h16, 5'h17: return 3;
      5'h19, 5'h1B: return 6;
      5'h1C, 5'h1D, 5'h1E, 5'h1F: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int modeCycles(input int m);
    case (m)
      2: return 3;
      3, 4, 5, 6: return 4;
      7: return 6;
      8: return 5;
      default: return 2;
    endcase
  endfunction

  function automatic int expClass(input logic [7:0] op);
    case (op)
      8'h02, 8'h12, 8'h22, 8'h32, 8'h42, 8'h52, 8'h62, 8'h72,
      8'h92, 8'hB2, 8'hD2, 8'hF2: return 3;
      8'h1A, 8'h3A, 8'h5A, 8'h7A, 8'hDA, 8'hFA: return 1;
      8'h04, 8'h44, 8'h64, 8'h0C, 8'h80, 8'h82, 8'h89, 8'hC2, 8'hE2,
      8'h14, 8'h34, 8'h54, 8'h74, 8'hD4, 8'hF4,
      8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'hDC, 8'hFC: return 2;
      8'h83, 8'h87, 8'h8F, 8'h97, 8'h93, 8'h9B, 8'h9C, 8'h9E, 8'h9F: return 5;
      8'hA3, 8'hA7, 8'hAF, 8'hB3, 8'hB7, 8'hBF, 8'hBB: return 6;
      8'h0B, 8'h2B, 8'h4B, 8'h6B, 8'h8B, 8'hAB, 8'hCB: return 7;
      8'h1B, 8'h3B, 8'h5B, 8'h7B, 8'hDB, 8'hFB: return 4;
      default: begin
        if ((op[3:0] == 4'h3 || op[3:0] == 4'h7 || op[3:0] == 4'hF) &&
            !(op[7:4] >= 4'h8 && op[7:4] <= 4'hB)) return 4;
        return 0;
      end
    endcase
  endfunction

  function automatic int expCycles(input logic [7:0] op);
    int c, mc;
    c  = expClass(op);
    mc = modeCycles(expMode(op));
    if (c == 3) return 0;
    if (c == 4) return mc + 2;
    if (c == 5 && op inside {8'h93, 8'h9B, 8'h9C, 8'h9E, 8'h9F}) return mc + 2;
    return mc;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reqForClass(input int c, output string r);
    case (c)
      1: r = "R1"; 2: r = "R2"; 3: r = "R3"; 4: r = "R8";
      5: r = "R9"; 6: r = "R10"; 7: r = "R11"; default: r = "R12";
    endcase
  endtask

  initial begin
    string rq;
    int badSweep;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    check("R5 reset halted", int'(halted), 0);
    check("R4 reset stall", int'(fetchStall), 0);

    // vector table: class, mode, cycles
    for (int i = 0; i < NV; i++) begin
      @(negedge clk) opcode = VEC[i][19:12];
      #1;
      reqForClass(int'(VEC[i][11:8]), rq);
      check({rq, " class"}, int'(opClass), int'(VEC[i][11:8]));
      check("R6 mode", int'(addrMode), int'(VEC[i][7:4]));
      check("R7 cycles", int'(baseCycles), int'(VEC[i][3:0]));
    end

    // full sweep against list model
    badSweep = 0;
    for (int op = 0; op < 256; op++) begin
      @(negedge clk) opcode = 8'(op);
      #1;
      if (int'(opClass) != expClass(8'(op)) || int'(addrMode) != expMode(8'(op)) ||
          int'(baseCycles) != expCycles(8'(op))) begin
        badSweep++;
        $display("FAIL R12 sweep op %02h: actual %0d/%0d/%0d expected %0d/%0d/%0d", op,
                 opClass, addrMode, baseCycles,
                 expClass(8'(op)), expMode(8'(op)), expCycles(8'(op)));
      end
    end
    nRun++;
    if (badSweep != 0) nFail++;

    // R4: jam without valid has no effect
    @(negedge clk) begin opcode = 8'h22; opValid = 1'b0; end
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R4 jam ignored without valid", int'(halted), 0);
    check("R4 stall low without valid", int'(fetchStall), 0);

    // R4: jam with valid sets halted after one edge
    @(negedge clk) begin opcode = 8'hB2; opValid = 1'b1; end
    #1;
    check("R4 not yet halted", int'(halted), 0);
    @(negedge clk) begin opcode = 8'hEA; opValid = 1'b1; end
    #1;
    check("R4 halted after jam", int'(halted), 1);
    check("R4 stall while halted", int'(fetchStall), 1);

    // R5: sticky across further valid opcodes
    for (int k = 0; k < 6; k++) begin
      @(negedge clk) opcode = (k % 2 == 0) ? 8'hA9 : 8'h12;
    end
    @(negedge clk) opValid = 1'b0;
    #1;
    check("R5 still halted", int'(halted), 1);
    check("R5 stall held", int'(fetchStall), 1);

    // R5: synchronous reset clears
    @(negedge clk) rst = 1'b1;
    #1;
    check("R5 clear waits for edge", int'(halted), 1);
    @(negedge clk) rst = 1'b0;
    #1;
    check("R5 cleared by reset", int'(halted), 0);
    check("R4 stall released", int'(fetchStall), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule